// File: doc/BRIEF.md
# Displacement and Immediate Assembler

This block gathers the bytes that trail an instruction's opcode: an optional address displacement followed by an optional immediate operand. A start pulse supplies the size of each field (none, byte, word or dword), the current data size and a sign-extension enable. The block then takes one byte per cycle in which `byte_valid_i` is high while it is busy. It places each byte little-endian into a shared accumulator, with the first byte at bit 0 and each later byte eight bits higher.

When the last byte is taken, the block splits the accumulator into two 32-bit results. The displacement comes from the low bytes and is sign-extended from its own size. The immediate is what remains once the accumulator is shifted right past the displacement. It is widened with its sign only when sign extension is enabled and the immediate size differs from the data size. While bytes are still owed, the block shows how many as a negative number. A decode stage starts it once the opcode is known and takes both results on the done pulse.

Size code on every size input: 0 = none (0 bytes), 1 = byte (1), 2 = word (2), 3 = dword (4).

Top module: `disp_imm_asm`

## Requirements
- R1: After reset `done_o`, `busy_o` and `byte_ready_o` are 0, and `remaining_o`, `disp_o` and `imm_o` are 0.
- R2: A start with sizes D and I needs exactly bytes(D)+bytes(I) accepted bytes. `busy_o` stays high until the clock edge that accepts the last of them. `done_o` rises right after that edge and is never high while `busy_o` is high.
- R3: Accepted byte number n (counting from 0 after start) lands in accumulator bits [8n+7:8n]. Cycles with `byte_valid_i` low add nothing and do not advance the count.
- R4: `disp_o` is the low bytes(D) bytes of the accumulator, sign-extended from bit 8·bytes(D)−1 to 32 bits, and 0 when D is none.
- R5: The raw immediate is the accumulator shifted right by 8·bytes(D). It appears unchanged on `imm_o` when the immediate size equals the data size or `sext_i` was 0.
- R6: When `sext_i` was 1 and the immediate size differs from the data size, `imm_o` is the raw immediate sign-extended from bit 8·bytes(I)−1, and 0 when I is none.
- R7: While busy, `remaining_o` equals −(bytes still owed) and rises by one for each accepted byte. When not busy it is 0.
- R8: A start with both sizes none takes no bytes. It raises `done_o` in the cycle after the start, with `disp_o` and `imm_o` both 0.
- R9: Bytes offered while not busy are ignored. `byte_ready_o` is low, `remaining_o` stays 0 and the results are unchanged.
- R10: A start while busy abandons the collection in progress and clears the accumulator and the count. Only bytes accepted after the new start form the result.
- R11: `done_o` is a one-cycle pulse. `disp_o` and `imm_o` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new collection; sizes sampled here |
| disp_size_i | input | 2 | Displacement size code |
| imm_size_i | input | 2 | Immediate size code |
| data_size_i | input | 2 | Current data size code |
| sext_i | input | 1 | Enable immediate sign extension |
| byte_valid_i | input | 1 | Incoming byte is valid |
| byte_i | input | 8 | Incoming byte |
| byte_ready_o | output | 1 | A byte offered this cycle is accepted |
| busy_o | output | 1 | Collection in progress |
| remaining_o | output | 5 | Signed: minus the bytes still owed |
| done_o | output | 1 | One-cycle completion pulse |
| disp_o | output | 32 | Sign-extended displacement |
| imm_o | output | 32 | Immediate, extended as required |

## Verification
A byte lane written at the wrong offset, or a count that advances on an idle cycle, shows up in `disp_o` or `imm_o` at the very next done pulse. A miscounted total shows up even earlier: `remaining_o` disagrees with the expected deficit on the first cycle after start, and done fires one byte early or late. The bench sweeps every combination of displacement size, immediate size, data size and extension flag. It uses byte values whose top bits vary, so both signs are exercised in every lane. Each result is checked against values built arithmetically from the bytes sent.

// File: rtl/disp_imm_pkg.sv
package disp_imm_pkg;
   typedef enum logic [1:0] {
      SZ_NONE  = 2'd0,
      SZ_BYTE  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } size_e;

   function automatic int sz_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 1;
         2'd2:    return 2;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/disp_imm_accum.sv
module disp_imm_accum #(
   parameter int LANES = 8,
   parameter int IDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic [IDX_W-1:0]     idx,
   input  logic [7:0]           byte_in,
   output logic [LANES*8-1:0]   merged_o
);
   logic [7:0] lane_q [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit = wr && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lane_q[g] <= '0;
         else if (clr)    lane_q[g] <= '0;
         else if (hit)    lane_q[g] <= lane_q[g] | byte_in;
      end
      assign merged_o[g*8 +: 8] = hit ? (lane_q[g] | byte_in) : lane_q[g];
   end
endmodule

// File: rtl/disp_imm_split.sv
module disp_imm_split
   import disp_imm_pkg::*;
#(
   parameter int ACC_W = 64,
   parameter int OUT_W = 32
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [1:0]       disp_sz,
   input  logic [1:0]       imm_sz,
   input  logic [1:0]       data_sz,
   input  logic             sext,
   output logic [OUT_W-1:0] disp_o,
   output logic [OUT_W-1:0] imm_o
);
   function automatic logic [OUT_W-1:0] widen(input logic [OUT_W-1:0] v, input int nbits);
      logic signed [OUT_W-1:0] t;
      int sh;
      if (nbits == 0) return '0;
      sh = OUT_W - nbits;
      t  = $signed(v << sh);
      return OUT_W'(t >>> sh);
   endfunction

   int                dbits;
   int                ibits;
   logic [OUT_W-1:0]  low_w;
   logic [OUT_W-1:0]  raw_w;

   always_comb begin
      dbits  = sz_bytes(disp_sz) * 8;
      ibits  = sz_bytes(imm_sz) * 8;
      low_w  = acc[OUT_W-1:0];
      raw_w  = OUT_W'(acc >> dbits);
      disp_o = widen(low_w, dbits);
      if ((imm_sz == data_sz) || !sext) imm_o = raw_w;
      else                              imm_o = widen(raw_w, ibits);
   end
endmodule

// File: rtl/disp_imm_asm.sv
module disp_imm_asm
   import disp_imm_pkg::*;
#(
   parameter int OUT_W = 32,
   parameter int LANES = 2 * (OUT_W / 8),
   localparam int ACC_W = LANES * 8,
   localparam int CNT_W = $clog2(LANES + 1),
   localparam int REM_W = CNT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [1:0]              disp_size_i,
   input  logic [1:0]              imm_size_i,
   input  logic [1:0]              data_size_i,
   input  logic                    sext_i,
   input  logic                    byte_valid_i,
   input  logic [7:0]              byte_i,
   output logic                    byte_ready_o,
   output logic                    busy_o,
   output logic signed [REM_W-1:0] remaining_o,
   output logic                    done_o,
   output logic [OUT_W-1:0]        disp_o,
   output logic [OUT_W-1:0]        imm_o
);
   if (OUT_W != 32) begin : g_bad_w
      $error("disp_imm_asm: OUT_W must be 32 to hold a dword field");
   end
   if (LANES < 2 * (OUT_W / 8)) begin : g_bad_lanes
      $error("disp_imm_asm: LANES too small for dword displacement plus dword immediate");
   end

   logic             busy_q, done_q;
   logic [CNT_W-1:0] cnt_q, total_q, total_in;
   logic [1:0]       dsz_q, isz_q, datsz_q;
   logic             sext_q;
   logic [OUT_W-1:0] disp_q, imm_q;
   logic             accept, last;
   logic [ACC_W-1:0] merged;
   logic [OUT_W-1:0] disp_c, imm_c;

   assign total_in = CNT_W'(sz_bytes(disp_size_i) + sz_bytes(imm_size_i));
   assign accept   = busy_q && byte_valid_i && !start_i;
   assign last     = accept && ((cnt_q + 1'b1) == total_q);

   disp_imm_accum #(.LANES(LANES), .IDX_W(CNT_W)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start_i),
      .wr       (accept),
      .idx      (cnt_q),
      .byte_in  (byte_i),
      .merged_o (merged)
   );

   disp_imm_split #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_split (
      .acc     (merged),
      .disp_sz (dsz_q),
      .imm_sz  (isz_q),
      .data_sz (datsz_q),
      .sext    (sext_q),
      .disp_o  (disp_c),
      .imm_o   (imm_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         total_q <= '0;
         dsz_q   <= '0;
         isz_q   <= '0;
         datsz_q <= '0;
         sext_q  <= 1'b0;
         disp_q  <= '0;
         imm_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            dsz_q   <= disp_size_i;
            isz_q   <= imm_size_i;
            datsz_q <= data_size_i;
            sext_q  <= sext_i;
            cnt_q   <= '0;
            total_q <= total_in;
            busy_q  <= (total_in != '0);
            if (total_in == '0) begin
               done_q <= 1'b1;
               disp_q <= '0;
               imm_q  <= '0;
            end
         end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               disp_q <= disp_c;
               imm_q  <= imm_c;
            end
         end
      end
   end

   assign byte_ready_o = busy_q;
   assign busy_o       = busy_q;
   assign done_o       = done_q;
   assign disp_o       = disp_q;
   assign imm_o        = imm_q;
   assign remaining_o  = busy_q ? ($signed({1'b0, cnt_q}) - $signed({1'b0, total_q}))
                                : '0;
endmodule

// File: rtl/disp_imm_asm_chk.sv
module disp_imm_asm_chk #(
   parameter int OUT_W = 32,
   parameter int REM_W = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [1:0]              disp_size_i,
   input logic [1:0]              imm_size_i,
   input logic                    byte_valid_i,
   input logic                    byte_ready_o,
   input logic                    busy_o,
   input logic signed [REM_W-1:0] remaining_o,
   input logic                    done_o,
   input logic [OUT_W-1:0]        disp_o,
   input logic [OUT_W-1:0]        imm_o
);
   AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o) else $error("done with busy"); // R2
   AST_LAST_BYTE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && byte_valid_i && !start_i && remaining_o == -1) |=> (done_o && !busy_o))
      else $error("last byte did not finish"); // R2
   AST_REMAIN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (remaining_o < 0)) else $error("busy without deficit"); // R7
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (remaining_o == 0)) else $error("idle deficit nonzero"); // R7
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && byte_valid_i && !start_i && remaining_o < -1) |=>
         (busy_o && remaining_o == $past(remaining_o) + 1)) else $error("bad step"); // R7
   AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && disp_size_i == 2'd0 && imm_size_i == 2'd0) |=> (done_o && !busy_o))
      else $error("empty start"); // R8
   AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> (!byte_ready_o && !busy_o)) else $error("idle accepted"); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o) else $error("done too long"); // R11
   AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(disp_o) && $stable(imm_o)))
      else $error("results moved"); // R11
endmodule

bind disp_imm_asm disp_imm_asm_chk #(.OUT_W(OUT_W), .REM_W(REM_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .disp_size_i  (disp_size_i),
   .imm_size_i   (imm_size_i),
   .byte_valid_i (byte_valid_i),
   .byte_ready_o (byte_ready_o),
   .busy_o       (busy_o),
   .remaining_o  (remaining_o),
   .done_o       (done_o),
   .disp_o       (disp_o),
   .imm_o        (imm_o)
);

// File: tb/disp_imm_asm_tb.sv
`timescale 1ns/1ps
module disp_imm_asm_tb;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [1:0]        disp_size_i = '0, imm_size_i = '0, data_size_i = '0;
   logic              sext_i = 1'b0;
   logic              byte_valid_i = 1'b0;
   logic [7:0]        byte_i = '0;
   logic              byte_ready_o, busy_o, done_o;
   logic signed [4:0] remaining_o;
   logic [31:0]       disp_o, imm_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   disp_imm_asm u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .disp_size_i(disp_size_i),
      .imm_size_i(imm_size_i), .data_size_i(data_size_i), .sext_i(sext_i),
      .byte_valid_i(byte_valid_i), .byte_i(byte_i), .byte_ready_o(byte_ready_o),
      .busy_o(busy_o), .remaining_o(remaining_o), .done_o(done_o),
      .disp_o(disp_o), .imm_o(imm_o)
   );

   function automatic int nb(input int code);
      return (code == 3) ? 4 : code;
   endfunction

   function automatic logic [31:0] ext_val(input longint v, input int nbytes, input bit sign);
      longint m, r;
      if (nbytes == 0) return 32'd0;
      m = (longint'(1) << (8 * nbytes));
      r = v % m;
      if (sign && r >= m / 2) r = r - m;
      return r[31:0];
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_start(input int d, input int i, input int ds, input bit sx);
      @(negedge clk);
      start_i = 1'b1; disp_size_i = d[1:0]; imm_size_i = i[1:0];
      data_size_i = ds[1:0]; sext_i = sx;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      byte_i = b; byte_valid_i = 1'b1;
      @(negedge clk);
      byte_valid_i = 1'b0;
   endtask

   task automatic run_case(input int d, input int i, input int ds, input bit sx, input int seed);
      int       total;
      longint   acc;
      logic [31:0] ed, ei;
      longint   raw;
      total = nb(d) + nb(i);
      acc = 0;
      do_start(d, i, ds, sx);
      if (total == 0) begin
         check(done_o && !busy_o, "R8 empty done", done_o, 1);
         check(disp_o == 0 && imm_o == 0, "R8 empty results", imm_o, 0);
      end
      for (int k = 0; k < total; k++) begin
         logic [7:0] b;
         b = 8'((seed * 53 + k * 97 + 8'h35) ^ ((seed + k) % 2 ? 8'h80 : 8'h00));
         check(remaining_o == -(total - k), "R7 deficit", remaining_o, -(total - k));
         check(busy_o && byte_ready_o && !done_o, "R2 busy while owed", busy_o, 1);
         if ((seed + k) % 3 == 0) begin
            byte_i = 8'hFF; byte_valid_i = 1'b0;
            @(negedge clk);
            check(remaining_o == -(total - k), "R3 idle cycle no advance", remaining_o, -(total - k));
         end
         send(b);
         acc = acc | (longint'(b) << (8 * k));
      end
      if (total != 0) begin
         ed  = ext_val(acc, nb(d), 1'b1);
         raw = acc >>> (8 * nb(d));
         if (i == ds || !sx) ei = raw[31:0];
         else                ei = ext_val(raw, nb(i), 1'b1);
         check(done_o && !busy_o, "R2 done after last byte", done_o, 1);
         check(disp_o == ed, (nb(d) == 0) ? "R4 disp none" : "R4 disp", disp_o, ed);
         check(imm_o == ei, (i == ds || !sx) ? "R5 imm pass" : "R6 imm sext", imm_o, ei);
         check(remaining_o == 0, "R7 zero when done", remaining_o, 0);
      end else begin
         ed = 0; ei = 0;
      end
      send(8'hA5);
      check(!done_o, "R11 done pulse", done_o, 0);
      check(!byte_ready_o && remaining_o == 0, "R9 idle ready", remaining_o, 0);
      check(disp_o == ed && imm_o == ei, "R9 R11 results held", imm_o, ei);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!done_o && !busy_o && !byte_ready_o, "R1 reset ctrl", done_o, 0);
      check(remaining_o == 0 && disp_o == 0 && imm_o == 0, "R1 reset data", disp_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int pass = 0; pass < 2; pass++)
         for (int d = 0; d < 4; d++)
            for (int i = 0; i < 4; i++)
               for (int ds = 0; ds < 4; ds++)
                  for (int sx = 0; sx < 2; sx++)
                     run_case(d, i, ds, sx[0], pass * 131 + d * 32 + i * 8 + ds * 2 + sx);
      // R10: restart mid-collection
      do_start(3, 3, 2, 1'b1);
      send(8'h11);
      send(8'h22);
      check(remaining_o == -6, "R10 before restart", remaining_o, -6);
      do_start(1, 1, 1, 1'b0);
      check(busy_o && remaining_o == -2, "R10 restart count", remaining_o, -2);
      send(8'h9C);
      send(8'h07);
      check(done_o && disp_o == 32'hFFFF_FF9C, "R10 restart disp", disp_o, 32'hFFFF_FF9C);
      check(imm_o == 32'h0000_0007, "R10 restart imm", imm_o, 7);
      @(negedge clk);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule